// File: doc/BRIEF.md
# Byte-Masked Random XOR Fuzzer

This block corrupts chosen bytes of a wide data word on purpose. It is meant for robustness testing, where well-formed traffic is altered before it reaches the unit under test. Each request carries a 256-bit word and a 32-bit byte-enable mask. The block turns every mask bit into a full byte of enable, ANDs that with a 256-bit pseudo-random value and XORs the result into the word. Bytes that are not enabled, such as checksums or addresses, reach the output untouched.

The random value is not made by one wide generator. Thirty-two 8-bit linear congruential lanes run side by side, and each lane supplies the byte at its own position. Every lane steps once for each accepted request. A request is taken whenever `in_valid` is high, and the result appears one clock later with `out_valid` high.

Top module: `byte_fuzzer`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is all zeros. Lane i holds its seed, (i*8'h1D + 8'h3B) mod 256, until the first request.
- R2: For an accepted request, output byte j (bits 8j+7:8j) equals input byte j XOR lane j's current value when mask bit j is 1, and equals input byte j when mask bit j is 0.
- R3: Each accepted request moves every lane i from state s to (5*s + 2*i + 1) mod 256.
- R4: In a cycle with `in_valid` low, no lane changes state.
- R5: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R6: `out_data` keeps its value through any cycle in which `in_valid` is low.
- R7: An all-zero mask returns the input word unchanged. An all-ones mask XORs every byte with its lane's value.
- R8: Lane i drives byte position i, aligned with mask bit i. With a single mask bit j set and zero data, only byte j of the output is nonzero, and it equals lane j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe; the request is accepted in every cycle it is high |
| in_data | input | 256 | Word to fuzz |
| in_mask | input | 32 | Byte enables; bit j enables corruption of byte j |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_data | output | 256 | Fuzzed word |

## Verification
The bench reads the lanes at the ports by sending a zero word with a full mask. A wrong seed or lane order then shows up as a wrong byte right after reset, and a wrong multiplier or increment shows up as a drift in the later states. Single-bit masks walked across the word check byte alignment. A swapped or reversed expansion would corrupt a neighbouring byte instead of the chosen one. Idle gaps between requests are checked for lanes that advance without a request, for a valid flag that stays high, and for output data that changes while no request is in flight. The all-zero mask case catches a stage that leaks random bits into bytes that are not enabled.

// File: rtl/fz_pkg.sv
package fz_pkg;
  function automatic logic [7:0] lane_seed(input int idx);
    return 8'((idx * 29) + 59);
  endfunction

  function automatic logic [7:0] lane_inc(input int idx);
    return 8'((2 * idx) + 1);
  endfunction
endpackage

// File: rtl/fz_rst_sync.sv
module fz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fz_lane.sv
module fz_lane #(
  parameter int          W    = 8,
  parameter int          MULT = 5,
  parameter logic [W-1:0] SEED = '0,
  parameter logic [W-1:0] INC  = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] MULT_W = W'(MULT);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (step) state_d = MULT_W * state_q + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= state_d;
  end

  assign state = state_q;

  // R4: lane holds without a request
  p_lane_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));

  // R3: full-period recurrence has no fixed point, so a step always moves
  p_lane_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state_q != $past(state_q));
endmodule

// File: rtl/fz_mask_expand.sv
module fz_mask_expand #(
  parameter int LANES  = 32,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [LANES-1:0]  mask,
  output logic [WORD_W-1:0] wide
);
  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign wide[g*LANE_W +: LANE_W] = {LANE_W{mask[g]}};
  end

  always_comb begin
    p_expand_zero_r7: assert (!(mask == '0) || wide == '0);
  end
endmodule

// File: rtl/fz_out_stage.sv
module fz_out_stage #(
  parameter int LANES  = 32,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LANES-1:0]  in_mask,
  input  logic [WORD_W-1:0] wide_mask,
  input  logic [WORD_W-1:0] rand_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = in_valid;
    dat_d = dat_q;
    if (in_valid) dat_d = in_data ^ (wide_mask & rand_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) dat_q <= dat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_zero_mask_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mask == '0) |=> out_data == $past(in_data));
endmodule

// File: rtl/byte_fuzzer.sv
module byte_fuzzer #(
  parameter int LANES  = 32,
  parameter int LANE_W = 8,
  parameter int MULT   = 5,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LANES-1:0]  in_mask,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] rand_word;
  logic [WORD_W-1:0] wide_mask;

  fz_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fz_lane #(
      .W    (LANE_W),
      .MULT (MULT),
      .SEED (LANE_W'(fz_pkg::lane_seed(i))),
      .INC  (LANE_W'(fz_pkg::lane_inc(i)))
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .step  (in_valid),
      .state (rand_word[i*LANE_W +: LANE_W])
    );
  end

  fz_mask_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_exp (
    .mask (in_mask),
    .wide (wide_mask)
  );

  fz_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_mask   (in_mask),
    .wide_mask (wide_mask),
    .rand_word (rand_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: tb/byte_fuzzer_bench.sv
module byte_fuzzer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] in_data = '0;
  logic [31:0]  in_mask = '0;
  logic         out_valid;
  logic [255:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] lane_m [32];

  always #5 clk = ~clk;

  byte_fuzzer u_byte_fuzzer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_mask(in_mask),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [255:0] model_out(logic [255:0] d, logic [31:0] m);
    logic [255:0] r = d;
    for (int j = 0; j < 32; j++)
      if (m[j]) r[j*8 +: 8] = d[j*8 +: 8] ^ lane_m[j];
    return r;
  endfunction

  task automatic model_step();
    for (int j = 0; j < 32; j++) lane_m[j] = 8'(5 * lane_m[j] + 2 * j + 1);
  endtask

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic request(string req, logic [255:0] d, logic [31:0] m);
    logic [255:0] exp;
    in_valid = 1'b1; in_data = d; in_mask = m;
    exp = model_out(d, m);
    @(negedge clk);
    model_step();
    check({req, "/R5 valid"}, {255'd0, out_valid}, 256'd1);
    check(req, out_data, exp);
  endtask

  task automatic idle(string req);
    logic [255:0] prev = out_data;
    in_valid = 1'b0; in_data = {8{$urandom()}}; in_mask = $urandom();
    @(negedge clk);
    check({req, "/R5 valid low"}, {255'd0, out_valid}, 256'd0);
    check({req, "/R6 hold"}, out_data, prev);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom();
    return r;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int j = 0; j < 32; j++) lane_m[j] = 8'(j * 29 + 59);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state of outputs
    check("R1 valid", {255'd0, out_valid}, 256'd0);
    check("R1 data", out_data, '0);
    // R1, R8: first read with zero data and full mask exposes the seeds
    begin
      logic [255:0] seeds;
      for (int j = 0; j < 32; j++) seeds[j*8 +: 8] = 8'(j * 29 + 59);
      check("R1 seeds model", model_out('0, '1), seeds);
    end
    request("R1 R8 seeds", '0, 32'hFFFF_FFFF);
    // R3: successive full-mask reads follow the recurrence
    request("R3 step1", '0, 32'hFFFF_FFFF);
    request("R3 step2", '0, 32'hFFFF_FFFF);
    // R4: idle cycles do not advance lanes
    idle("R4 gap");
    idle("R4 gap");
    idle("R4 gap");
    request("R4 no advance", '0, 32'hFFFF_FFFF);
    // R7: all-zero mask passes input
    request("R7 zero mask", rnd256(), 32'h0);
    request("R7 zero mask", {8{32'hDEAD_BEEF}}, 32'h0);
    // R7: all-ones mask on random data
    request("R7 ones mask", rnd256(), 32'hFFFF_FFFF);
    // R8: walking single-bit masks with zero data
    for (int j = 0; j < 32; j += 5) request("R8 walk", '0, 32'h1 << j);
    request("R8 top byte", '0, 32'h8000_0000);
    // R2: random data and masks with random idle gaps
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(3) == 0) idle("R2 gap");
      request("R2 random", rnd256(), $urandom());
    end
    request("R3 final", '0, 32'hFFFF_FFFF);
    in_valid = 1'b0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule